// File: doc/BRIEF.md
# SCSI Host DMA Channel Register Engine

This block is the control unit of one bus-master DMA channel in a SCSI host adapter. It holds the channel's eight 32-bit registers: command, starting count, starting address, working count, working address, status, starting descriptor-list address and working descriptor-list address. Software reaches these registers through a port that selects one word by index.

A command write decodes a two-bit operation field. A start operation copies the three starting registers into their working copies, clears the status bits and enables DMA. An abort operation sends a one-cycle cancel pulse to the SCSI core. The transfer side of the adapter offers chunks through a length/strobe interface. The engine accepts a chunk only when its direction agrees with the command register, clips it to the remaining count and advances the working count and address.

Status bits are sticky. A separate bus-control register selects how they are cleared: by writing ones, or by reading them. The SCSI-interrupt status bit is not stored; it follows the core's interrupt line.

Top module: `sdma_chan`

## Requirements
- R1: After reset the command register reads 0, the working count reads 0, the working address reads 0xFFFFFFFF, the working descriptor address reads 0xFFFFFFFD, status reads 0, and `dma_en` and `core_cancel` are 0.
- R2: A write to index 0 stores the whole word. Bits [1:0] select the operation. With 0 (idle), `dma_en` is 0 from the next cycle. With 1 (blast), nothing else changes. With 2 (abort), `core_cancel` is high for exactly the next cycle. With 3 (start), the start actions of R3 apply.
- R3: A start operation loads index 3 from index 1, index 4 from index 2 and index 7 from index 6. It clears status bits [5:0] and sets `dma_en`, all visible on the following cycle.
- R4: Writes to indices 1, 2 and 6 store the word and read back unchanged. Writes to indices 3, 4 and 7 are ignored.
- R5: A chunk request is accepted (`xfer_ok`=1) when `xfer_dir` equals command bit 7, where 1 means device to memory. The granted `xfer_chunk` is the smaller of `xfer_len` and the working count. On the next cycle the working count has dropped by the chunk and the working address has risen by it.
- R6: A chunk request whose direction differs from command bit 7 gives `xfer_ok`=0 and leaves the working count and working address unchanged.
- R7: A `core_done` pulse forces the working count to 0 and sets status bit 3 (done) on the next cycle. This overrides a start or a chunk issued in the same cycle.
- R8: When bus-control bit 12 is 0, a write to index 5 clears each of status bits 1, 2 and 3 that is written as 1 and leaves the other bits alone.
- R9: When bus-control bit 12 is 1, writes to index 5 are ignored. A read of index 5 returns the current bits, and status bits 1, 2 and 3 are clear from the next cycle.
- R10: A read of index 5 shows bit 4 equal to `core_irq` in the same cycle. Bit 4 is never stored.
- R11: The bus-control register is written through `ctl_wr`/`ctl_wdata` and its value appears on `ctl_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has side effects on status) |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_idx` |
| ctl_wr | input | 1 | Bus-control register write strobe |
| ctl_wdata | input | 32 | Bus-control write data |
| ctl_q | output | 32 | Bus-control register value |
| core_irq | input | 1 | Interrupt level from the SCSI core |
| core_done | input | 1 | Command-complete pulse from the SCSI core |
| core_cancel | output | 1 | One-cycle request cancel pulse to the SCSI core |
| dma_en | output | 1 | DMA enable to the SCSI core |
| xfer_req | input | 1 | Chunk request strobe |
| xfer_dir | input | 1 | Chunk direction, 1 = device to memory |
| xfer_len | input | LEN_W | Requested chunk length |
| xfer_ok | output | 1 | Chunk accepted |
| xfer_chunk | output | LEN_W | Granted chunk length |

## Verification
The embedded properties check on every cycle that:
- a granted chunk never exceeds the request or the remaining count;
- a rejected chunk freezes both counters;
- a start loads the working registers and clears status;
- a completion pulse zeroes the count and sets done;
- abort produces its cancel pulse and idle drops the enable;
- status bit 4 tracks the interrupt line.

Only the bench scenarios can show the following: the two clear policies working in sequence, the old value returned by a clear-on-read, writes to the working indices being ignored, the override when completion and start coincide, and the running arithmetic over a series of chunks of both directions.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } sdma_op_e;

  localparam logic [IDX_W-1:0] IX_CMD  = 3'd0;
  localparam logic [IDX_W-1:0] IX_SCNT = 3'd1;
  localparam logic [IDX_W-1:0] IX_SADR = 3'd2;
  localparam logic [IDX_W-1:0] IX_WCNT = 3'd3;
  localparam logic [IDX_W-1:0] IX_WADR = 3'd4;
  localparam logic [IDX_W-1:0] IX_STAT = 3'd5;
  localparam logic [IDX_W-1:0] IX_SDSC = 3'd6;
  localparam logic [IDX_W-1:0] IX_WDSC = 3'd7;

  localparam int unsigned CMD_DIR_BIT = 7;
  localparam int unsigned CTL_COR_BIT = 12;
  localparam int unsigned ST_W        = 6;
  localparam int unsigned ST_DONE     = 3;
  localparam int unsigned ST_IRQ      = 4;
  localparam logic [ST_W-1:0] ST_CLR_MASK = 6'b001110;

  // Granted chunk: the request, clipped to what remains.
  function automatic logic [DW-1:0] sdma_clip(input logic [DW-1:0] req,
                                              input logic [DW-1:0] left);
    return (req < left) ? req : left;
  endfunction

  // Status bits removed this cycle.
  function automatic logic [ST_W-1:0] sdma_clr(input logic start,
                                               input logic cor_mode,
                                               input logic wr_hit,
                                               input logic rd_hit,
                                               input logic [ST_W-1:0] wbits);
    if (start)                  return '1;
    else if (!cor_mode && wr_hit) return wbits & ST_CLR_MASK;
    else if (cor_mode && rd_hit)  return ST_CLR_MASK;
    else                        return '0;
  endfunction
endpackage

// File: rtl/sdma_xfer.sv
module sdma_xfer
  import sdma_pkg::*;
#(
  parameter int unsigned LEN_W    = 16,
  parameter logic [31:0] WADR_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] WDSC_RST = 32'hFFFF_FFFD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             done_evt,
  input  logic [DW-1:0]    scnt,
  input  logic [DW-1:0]    sadr,
  input  logic [DW-1:0]    sdsc,
  input  logic             dir_cfg,
  input  logic             xfer_req,
  input  logic             xfer_dir,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             xfer_ok,
  output logic [LEN_W-1:0] xfer_chunk,
  output logic [DW-1:0]    wcnt,
  output logic [DW-1:0]    wadr,
  output logic [DW-1:0]    wdsc
);
  localparam int unsigned PAD_W = DW - LEN_W;

  logic [DW-1:0] len_ext;
  logic [DW-1:0] chunk_w;

  assign xfer_ok    = xfer_req && (xfer_dir == dir_cfg);
  assign len_ext    = {{PAD_W{1'b0}}, xfer_len};
  assign chunk_w    = sdma_clip(len_ext, wcnt);
  assign xfer_chunk = chunk_w[LEN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      wadr <= WADR_RST;
      wdsc <= WDSC_RST;
    end else begin
      if (start) begin
        wcnt <= scnt;
        wadr <= sadr;
        wdsc <= sdsc;
      end else if (xfer_ok) begin
        wcnt <= wcnt - chunk_w;
        wadr <= wadr + chunk_w;
      end
      if (done_evt) wcnt <= '0;
    end
  end

  p_chunk_clip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ok |-> (chunk_w <= wcnt) && (chunk_w <= len_ext));

  p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ok && !start && !done_evt) |=> $stable(wcnt) && $stable(wadr));

  p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !done_evt) |=> (wcnt == $past(scnt)) && (wadr == $past(sadr))
                             && (wdsc == $past(sdsc)));

  p_done_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (wcnt == '0));
endmodule

// File: rtl/sdma_stat.sv
module sdma_stat
  import sdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            done_evt,
  input  logic            cor_mode,
  input  logic            wr_hit,
  input  logic            rd_hit,
  input  logic [ST_W-1:0] wbits,
  input  logic            core_irq,
  output logic [ST_W-1:0] stat_q,
  output logic [DW-1:0]   stat_view
);
  logic [ST_W-1:0] clr_w;
  logic [ST_W-1:0] set_w;

  assign clr_w = sdma_clr(start, cor_mode, wr_hit, rd_hit, wbits);
  assign set_w = ST_W'(done_evt) << ST_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= ((stat_q & ~clr_w) | set_w) & ~(ST_W'(1) << ST_IRQ);
  end

  always_comb begin
    stat_view = {{(DW-ST_W){1'b0}}, stat_q};
    stat_view[ST_IRQ] = core_irq;
  end

  p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> stat_q[ST_DONE]);

  p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !done_evt) |=> (stat_q == '0));

  p_cor_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_mode && !rd_hit && !start && !done_evt) |=> $stable(stat_q));

  p_irq_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_view[ST_IRQ] == core_irq) && !stat_q[ST_IRQ]);
endmodule

// File: rtl/sdma_chan.sv
module sdma_chan
  import sdma_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_idx,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ctl_wr,
  input  logic [31:0]      ctl_wdata,
  output logic [31:0]      ctl_q,
  input  logic             core_irq,
  input  logic             core_done,
  output logic             core_cancel,
  output logic             dma_en,
  input  logic             xfer_req,
  input  logic             xfer_dir,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             xfer_ok,
  output logic [LEN_W-1:0] xfer_chunk
);
  logic [DW-1:0] cmd_q, scnt_q, sadr_q, sdsc_q;
  logic [DW-1:0] wcnt, wadr, wdsc, stat_view;
  logic [ST_W-1:0] stat_q;
  sdma_op_e op_w;
  logic cmd_hit, start_evt, abort_evt, idle_evt, stat_wr_hit, stat_rd_hit;

  assign op_w        = sdma_op_e'(reg_wdata[1:0]);
  assign cmd_hit     = reg_wr && (reg_idx == IX_CMD);
  assign start_evt   = cmd_hit && (op_w == OP_START);
  assign abort_evt   = cmd_hit && (op_w == OP_ABORT);
  assign idle_evt    = cmd_hit && (op_w == OP_IDLE);
  assign stat_wr_hit = reg_wr && (reg_idx == IX_STAT);
  assign stat_rd_hit = reg_rd && (reg_idx == IX_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; scnt_q <= '0; sadr_q <= '0; sdsc_q <= '0; ctl_q <= '0;
      dma_en <= 1'b0; core_cancel <= 1'b0;
    end else begin
      core_cancel <= abort_evt;
      if (start_evt)     dma_en <= 1'b1;
      else if (idle_evt) dma_en <= 1'b0;
      if (ctl_wr) ctl_q <= ctl_wdata;
      if (reg_wr) begin
        unique case (reg_idx)
          IX_CMD:  cmd_q  <= reg_wdata;
          IX_SCNT: scnt_q <= reg_wdata;
          IX_SADR: sadr_q <= reg_wdata;
          IX_SDSC: sdsc_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  sdma_xfer #(.LEN_W(LEN_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .done_evt(core_done),
    .scnt(scnt_q), .sadr(sadr_q), .sdsc(sdsc_q), .dir_cfg(cmd_q[CMD_DIR_BIT]),
    .xfer_req(xfer_req), .xfer_dir(xfer_dir), .xfer_len(xfer_len),
    .xfer_ok(xfer_ok), .xfer_chunk(xfer_chunk),
    .wcnt(wcnt), .wadr(wadr), .wdsc(wdsc)
  );

  sdma_stat u_stat (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .done_evt(core_done),
    .cor_mode(ctl_q[CTL_COR_BIT]), .wr_hit(stat_wr_hit), .rd_hit(stat_rd_hit),
    .wbits(reg_wdata[ST_W-1:0]), .core_irq(core_irq),
    .stat_q(stat_q), .stat_view(stat_view)
  );

  always_comb begin
    unique case (reg_idx)
      IX_CMD:  reg_rdata = cmd_q;
      IX_SCNT: reg_rdata = scnt_q;
      IX_SADR: reg_rdata = sadr_q;
      IX_WCNT: reg_rdata = wcnt;
      IX_WADR: reg_rdata = wadr;
      IX_STAT: reg_rdata = stat_view;
      IX_SDSC: reg_rdata = sdsc_q;
      default: reg_rdata = wdsc;
    endcase
  end

  p_abort_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> core_cancel);

  p_cancel_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_evt |=> !core_cancel);

  p_idle_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |=> !dma_en);

  p_ctl_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_q == $past(ctl_wdata)));
endmodule

// File: tb/sdma_chan_bench.sv
module sdma_chan_bench;
  localparam int LEN_W = 16;

  typedef struct packed {
    logic        dir;
    logic [15:0] len;
    logic        ok;
    logic [15:0] chunk;
  } vec_t;

  // Start count 100, command direction 0.
  localparam vec_t VEC [0:4] = '{
    '{1'b0, 16'd30, 1'b1, 16'd30},
    '{1'b1, 16'd10, 1'b0, 16'd0},
    '{1'b0, 16'd50, 1'b1, 16'd50},
    '{1'b0, 16'd40, 1'b1, 16'd20},
    '{1'b0, 16'd7,  1'b1, 16'd0}
  };

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, ctl_wr = 0;
  logic [2:0] reg_idx = 0;
  logic [31:0] reg_wdata = 0, ctl_wdata = 0, reg_rdata, ctl_q;
  logic core_irq = 0, core_done = 0, core_cancel, dma_en;
  logic xfer_req = 0, xfer_dir = 0, xfer_ok;
  logic [LEN_W-1:0] xfer_len = 0, xfer_chunk;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdma_chan #(.LEN_W(LEN_W)) u_sdma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .core_irq(core_irq),
    .core_done(core_done), .core_cancel(core_cancel), .dma_en(dma_en),
    .xfer_req(xfer_req), .xfer_dir(xfer_dir), .xfer_len(xfer_len),
    .xfer_ok(xfer_ok), .xfer_chunk(xfer_chunk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_idx = idx; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] q);
    @(negedge clk); reg_rd = 1; reg_idx = idx; #1 q = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rdchk(input string req, input logic [2:0] idx, input logic [31:0] exp);
    logic [31:0] q;
    rd(idx, q);
    chk(req, q, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); core_done = 1;
    @(negedge clk); core_done = 0;
  endtask

  task automatic ctl_set(input logic [31:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic reset_checks();
    chk("R1 dma_en", {31'd0, dma_en}, 32'd0);
    chk("R1 core_cancel", {31'd0, core_cancel}, 32'd0);
    rdchk("R1 cmd", 3'd0, 32'd0);
    rdchk("R1 wcnt", 3'd3, 32'd0);
    rdchk("R1 wadr", 3'd4, 32'hFFFF_FFFF);
    rdchk("R1 wdsc", 3'd7, 32'hFFFF_FFFD);
    rdchk("R1 stat", 3'd5, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] wc, wa, q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    reset_checks();

    // R4: starting registers store; working indices ignore writes
    wr(3'd1, 32'd100); wr(3'd2, 32'h0000_1000); wr(3'd6, 32'h0000_2000);
    wr(3'd3, 32'd5); wr(3'd4, 32'd5); wr(3'd7, 32'd5);
    rdchk("R4 scnt", 3'd1, 32'd100);
    rdchk("R4 sadr", 3'd2, 32'h1000);
    rdchk("R4 sdsc", 3'd6, 32'h2000);
    rdchk("R4 wcnt ignored", 3'd3, 32'd0);
    rdchk("R4 wadr ignored", 3'd4, 32'hFFFF_FFFF);
    rdchk("R4 wdsc ignored", 3'd7, 32'hFFFF_FFFD);

    // R3: start
    wr(3'd0, 32'h0000_0003);
    chk("R3 dma_en", {31'd0, dma_en}, 32'd1);
    rdchk("R2 cmd stored", 3'd0, 32'd3);
    rdchk("R3 wcnt", 3'd3, 32'd100);
    rdchk("R3 wadr", 3'd4, 32'h1000);
    rdchk("R3 wdsc", 3'd7, 32'h2000);

    // R5/R6 vector table
    wc = 100; wa = 32'h1000;
    foreach (VEC[i]) begin
      @(negedge clk);
      xfer_req = 1; xfer_dir = VEC[i].dir; xfer_len = VEC[i].len;
      #1;
      chk(VEC[i].ok ? "R5 ok" : "R6 ok", {31'd0, xfer_ok}, {31'd0, VEC[i].ok});
      if (VEC[i].ok) begin
        chk("R5 chunk", {16'd0, xfer_chunk}, {16'd0, VEC[i].chunk});
        q = (32'(VEC[i].len) < wc) ? 32'(VEC[i].len) : wc;
        wc = wc - q; wa = wa + q;
      end
      @(negedge clk); xfer_req = 0;
      rdchk("R5 R6 wcnt", 3'd3, wc);
      rdchk("R5 R6 wadr", 3'd4, wa);
    end

    // R2 blast: nothing changes
    wr(3'd0, 32'h0000_0001);
    chk("R2 blast dma_en", {31'd0, dma_en}, 32'd1);
    chk("R2 blast cancel", {31'd0, core_cancel}, 32'd0);
    rdchk("R2 blast wcnt", 3'd3, wc);

    // R2 abort: one-cycle cancel
    wr(3'd0, 32'h0000_0002);
    chk("R2 abort cancel", {31'd0, core_cancel}, 32'd1);
    @(negedge clk);
    chk("R2 abort cancel one cycle", {31'd0, core_cancel}, 32'd0);

    // R7 done
    wr(3'd0, 32'h0000_0003);
    pulse_done();
    rdchk("R7 done bit", 3'd5, 32'h08);
    rdchk("R7 wcnt zero", 3'd3, 32'd0);

    // R10 live interrupt
    core_irq = 1;
    rdchk("R10 irq high", 3'd5, 32'h18);
    core_irq = 0;
    rdchk("R10 irq not stored", 3'd5, 32'h08);

    // R8 write-one-to-clear
    wr(3'd5, 32'h04);
    rdchk("R8 other bit", 3'd5, 32'h08);
    wr(3'd5, 32'h08);
    rdchk("R8 cleared", 3'd5, 32'h00);

    // R11 / R9 clear-on-read
    ctl_set(32'h0000_1000);
    chk("R11 ctl_q", ctl_q, 32'h1000);
    pulse_done();
    wr(3'd5, 32'h08);
    rdchk("R9 write ignored old value", 3'd5, 32'h08);
    rdchk("R9 cleared after read", 3'd5, 32'h00);

    // R3 start clears status
    pulse_done();
    wr(3'd0, 32'h0000_0003);
    rdchk("R3 status cleared", 3'd5, 32'h00);
    rdchk("R3 reload wcnt", 3'd3, 32'd100);

    // R7 done overrides start in same cycle
    @(negedge clk); reg_wr = 1; reg_idx = 3'd0; reg_wdata = 32'h3; core_done = 1;
    @(negedge clk); reg_wr = 0; core_done = 0;
    rdchk("R7 override stat", 3'd5, 32'h08);
    rdchk("R7 override wcnt", 3'd3, 32'd0);

    // R2 idle
    wr(3'd0, 32'h0000_0000);
    chk("R2 idle dma_en", {31'd0, dma_en}, 32'd0);

    // R5/R6 device-to-memory direction
    wr(3'd0, 32'h0000_0083);
    @(negedge clk); xfer_req = 1; xfer_dir = 1; xfer_len = 16'd10;
    #1 chk("R5 dir1 ok", {31'd0, xfer_ok}, 32'd1);
    @(negedge clk); xfer_dir = 0;
    #1 chk("R6 dir0 rejected", {31'd0, xfer_ok}, 32'd0);
    @(negedge clk); xfer_req = 0;
    rdchk("R5 R6 dir1 wcnt", 3'd3, 32'd90);
    rdchk("R5 R6 dir1 wadr", 3'd4, 32'h100A);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    reset_checks();
    chk("R1 ctl_q", ctl_q, 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule